// File: doc/BRIEF.md
# Interrupt Request Front End

This block collects interrupt requests from a small 8-bit controller's sources, holds them in per-channel request flags and presents the single highest-priority request that is both pending and enabled to the core. Each channel carries an enable bit and a routing bit. The routing bit decides whether the winning request is serviced by the normal interrupt sequence or handed to a micro-DMA transfer. Software reaches the enable byte, the routing byte, a configuration byte and the request-flag byte through a small register port.

Channel 0 is an external pin. The pin is brought through a synchronizer and works in edge mode or level mode. In level mode the pending bit follows the synchronized pin directly, and the request flag is not used. Channel 1 is shared between a timer event and an ADC completion event, and a configuration bit chooses between them. Channel 2 is the serial receive channel. The ADC source and the receive channel can only be cleared by a read of their peripheral data register. Channels 3 and up are general event channels.

The register word width equals the channel count, which is 8 by default.

Top module: `irq_ctrl_front`

## Requirements
- R1: After reset the enable, routing, configuration and flag registers all read 0, and `irq_valid` is 0.
- R2: `reg_addr` selects the register. Offset 0 is enable (bit i = channel i), offset 1 is routing (1 = micro-DMA), offset 2 is configuration (bit 0 = pin level mode, bit 1 = shared source is ADC) and offset 3 is the pending flags. Read data is combinational. A write takes effect at the clock edge that samples `reg_wr`.
- R3: In edge mode a rising pin edge sets channel 0's flag. The flag can be seen on the outputs after the third clock edge that follows the pin change, and not after the second. It then holds whether the pin stays high or falls.
- R4: In level mode, pending bit 0 is the pin delayed by two synchronizer stages. An acknowledge does not remove it.
- R5: Any write that changes the pin mode bit clears channel 0's flag. A flag set in edge mode is therefore gone after a round trip through level mode.
- R6: With source bit 0 only `timer_evt` sets channel 1, and with source bit 1 only `adc_evt` sets it. The other source is ignored.
- R7: Any write that changes the source bit clears channel 1's flag.
- R8: While the ADC is selected, channel 1's flag ignores software clear writes and acknowledges. It clears only on `adc_result_rd`.
- R9: Channel 2's flag ignores software clear writes and acknowledges. It clears only on `rx_buf_rd`.
- R10: `irq_valid` is 1 when some channel is both pending and enabled. `irq_chan` is then the lowest such channel index. A pending but disabled channel is not presented.
- R11: `irq_to_dma` equals the routing bit of the presented channel.
- R12: On the other channels (channel 0 in edge mode, channel 1 with the timer source, channels 3 and up), the flag is cleared by `irq_ack` while the channel is presented, or by writing 1 to its bit at offset 3. A new event arriving in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| timer_evt | input | 1 | Timer event pulse for the shared channel |
| adc_evt | input | 1 | ADC completion pulse for the shared channel |
| rx_evt | input | 1 | Serial receive event pulse |
| gen_evt | input | NUM_CH-3 | Event pulses for channels 3 and up |
| adc_result_rd | input | 1 | Pulse when the ADC result register is read |
| rx_buf_rd | input | 1 | Pulse when the receive buffer is read |
| reg_addr | input | 2 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | NUM_CH | Register write data |
| reg_rdata | output | NUM_CH | Register read data |
| irq_valid | output | 1 | A pending, enabled request is presented |
| irq_chan | output | clog2(NUM_CH) | Index of the presented channel |
| irq_to_dma | output | 1 | Presented request is routed to micro-DMA |
| irq_ack | input | 1 | Acknowledge of the presented request |

## Verification
The assertions assume that the peripheral read strobes and event inputs are single-cycle pulses that are synchronous to `clk`. They also assume that `irq_ack` is raised only while `irq_valid` is high. Only the external pin is allowed to change asynchronously. The bench drives every input on the falling edge. It pulses events and strobes for exactly one cycle, and it acknowledges only after it has seen a valid request. Before each flag-clearing check it waits long enough for the pin to pass through the synchronizer.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // fixed channel roles
  localparam int CH_PIN    = 0;
  localparam int CH_SHARED = 1;
  localparam int CH_RX     = 2;
  localparam int CH_GEN0   = 3;

  // configuration bit positions
  localparam int CFG_LEVEL_BIT = 0;
  localparam int CFG_SRC_BIT   = 1;

  typedef enum logic [1:0] {
    REG_EN   = 2'd0,
    REG_DMA  = 2'd1,
    REG_CFG  = 2'd2,
    REG_FLAG = 2'd3
  } reg_sel_e;

  // a bit changes when a write carries a value different from the stored one
  function automatic logic bit_changes(input logic wr, input logic new_v, input logic old_v);
    return wr && (new_v != old_v);
  endfunction
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic pin_sync,
  output logic pin_rise
);
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SYNC_STAGES-1:0], pin_async};
  end

  assign pin_sync = sh_q[SYNC_STAGES-1];
  assign pin_rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
endmodule

// File: rtl/irq_req_flag.sv
module irq_req_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic force_clr_i,
  output logic flag_o
);
  // forced clear wins, then a new event, then an ordinary clear
  always_ff @(posedge clk) begin
    if (!rst_n)           flag_o <= 1'b0;
    else if (force_clr_i) flag_o <= 1'b0;
    else if (set_i)       flag_o <= 1'b1;
    else if (clr_i)       flag_o <= 1'b0;
  end
endmodule

// File: rtl/irq_priority.sv
module irq_priority #(
  parameter int NUM_CH = 8,
  localparam int IDXW = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] active,
  output logic              any_o,
  output logic [IDXW-1:0]   idx_o
);
  function automatic logic [IDXW-1:0] lowest_set(input logic [NUM_CH-1:0] v);
    logic [IDXW-1:0] r;
    r = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (v[i]) r = IDXW'(i);
    end
    return r;
  endfunction

  assign any_o = |active;
  assign idx_o = lowest_set(active);
endmodule

// File: rtl/irq_ctrl_front.sv
module irq_ctrl_front
  import irq_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int IDXW = $clog2(NUM_CH),
  localparam int NGEN = NUM_CH - CH_GEN0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_pin,
  input  logic              timer_evt,
  input  logic              adc_evt,
  input  logic              rx_evt,
  input  logic [NGEN-1:0]   gen_evt,
  input  logic              adc_result_rd,
  input  logic              rx_buf_rd,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [NUM_CH-1:0] reg_wdata,
  output logic [NUM_CH-1:0] reg_rdata,
  output logic              irq_valid,
  output logic [IDXW-1:0]   irq_chan,
  output logic              irq_to_dma,
  input  logic              irq_ack
);
  logic [NUM_CH-1:0] en_q, dma_q;
  logic              level_q, src_q;

  // named internal events
  logic wr_en, wr_dma, wr_cfg, wr_flag;
  logic mode_chg, src_chg;
  logic pin_sync, pin_rise;
  logic [NUM_CH-1:0] sw_clr, ack_vec;
  logic [NUM_CH-1:0] set_v, clr_v, frc_v;
  logic [NUM_CH-1:0] flag_v, pend_vec, active_v;

  assign wr_en   = reg_wr && (reg_addr == REG_EN);
  assign wr_dma  = reg_wr && (reg_addr == REG_DMA);
  assign wr_cfg  = reg_wr && (reg_addr == REG_CFG);
  assign wr_flag = reg_wr && (reg_addr == REG_FLAG);

  assign mode_chg = bit_changes(wr_cfg, reg_wdata[CFG_LEVEL_BIT], level_q);
  assign src_chg  = bit_changes(wr_cfg, reg_wdata[CFG_SRC_BIT], src_q);

  assign sw_clr  = wr_flag ? reg_wdata : '0;
  assign ack_vec = (irq_ack && irq_valid) ? (NUM_CH'(1) << irq_chan) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      dma_q   <= '0;
      level_q <= 1'b0;
      src_q   <= 1'b0;
    end else begin
      if (wr_en)  en_q  <= reg_wdata;
      if (wr_dma) dma_q <= reg_wdata;
      if (wr_cfg) begin
        level_q <= reg_wdata[CFG_LEVEL_BIT];
        src_q   <= reg_wdata[CFG_SRC_BIT];
      end
    end
  end

  irq_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_async(ext_pin),
    .pin_sync (pin_sync),
    .pin_rise (pin_rise)
  );

  // per-channel set / clear / forced-clear rules
  always_comb begin
    set_v = '0;
    clr_v = '0;
    frc_v = '0;
    // external pin: flag used only in edge mode
    set_v[CH_PIN] = ~level_q & pin_rise;
    clr_v[CH_PIN] = sw_clr[CH_PIN] | ack_vec[CH_PIN];
    frc_v[CH_PIN] = mode_chg;
    // shared timer / ADC channel
    set_v[CH_SHARED] = src_q ? adc_evt : timer_evt;
    clr_v[CH_SHARED] = src_q ? adc_result_rd
                             : (sw_clr[CH_SHARED] | ack_vec[CH_SHARED]);
    frc_v[CH_SHARED] = src_chg;
    // serial receive: cleared by buffer read only
    set_v[CH_RX] = rx_evt;
    clr_v[CH_RX] = rx_buf_rd;
    // general event channels
    for (int i = CH_GEN0; i < NUM_CH; i++) begin
      set_v[i] = gen_evt[i - CH_GEN0];
      clr_v[i] = sw_clr[i] | ack_vec[i];
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_flag
    irq_req_flag u_flag (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_i      (set_v[g]),
      .clr_i      (clr_v[g]),
      .force_clr_i(frc_v[g]),
      .flag_o     (flag_v[g])
    );
  end

  always_comb begin
    pend_vec = flag_v;
    if (level_q) pend_vec[CH_PIN] = pin_sync;
  end

  assign active_v = pend_vec & en_q;

  irq_priority #(.NUM_CH(NUM_CH)) u_prio (
    .active(active_v),
    .any_o (irq_valid),
    .idx_o (irq_chan)
  );

  assign irq_to_dma = dma_q[irq_chan];

  always_comb begin
    unique case (reg_addr)
      REG_EN:   reg_rdata = en_q;
      REG_DMA:  reg_rdata = dma_q;
      REG_CFG:  begin
        reg_rdata = '0;
        reg_rdata[CFG_LEVEL_BIT] = level_q;
        reg_rdata[CFG_SRC_BIT]   = src_q;
      end
      default:  reg_rdata = pend_vec;
    endcase
  end
endmodule

// File: rtl/irq_ctrl_front_chk.sv
module irq_ctrl_front_chk
  import irq_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int IDXW = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              level_q,
  input logic              src_q,
  input logic              mode_chg,
  input logic              src_chg,
  input logic              adc_result_rd,
  input logic              rx_buf_rd,
  input logic [NUM_CH-1:0] flag_v,
  input logic [NUM_CH-1:0] pend_vec,
  input logic [NUM_CH-1:0] en_q,
  input logic [NUM_CH-1:0] dma_q,
  input logic              irq_valid,
  input logic [IDXW-1:0]   irq_chan,
  input logic              irq_to_dma
);
  assert_level_flag_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    level_q |=> !flag_v[CH_PIN]);

  assert_mode_change_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> !flag_v[CH_PIN]);

  assert_src_change_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    src_chg |=> !flag_v[CH_SHARED]);

  assert_adc_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q && flag_v[CH_SHARED] && !adc_result_rd && !src_chg) |=> flag_v[CH_SHARED]);

  assert_rx_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_v[CH_RX] && !rx_buf_rd) |=> flag_v[CH_RX]);

  assert_winner_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (pend_vec[irq_chan] && en_q[irq_chan]));

  assert_no_lower_winner_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (((pend_vec & en_q) & ((NUM_CH'(1) << irq_chan) - NUM_CH'(1))) == '0));

  assert_route_bit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_to_dma == dma_q[irq_chan]));
endmodule

bind irq_ctrl_front irq_ctrl_front_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/irq_ctrl_front_test.sv
`timescale 1ns/1ps
module irq_ctrl_front_test;
  localparam int NUM_CH = 8;
  localparam int NGEN   = NUM_CH - 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_pin = 1'b0, timer_evt = 1'b0, adc_evt = 1'b0, rx_evt = 1'b0;
  logic [NGEN-1:0] gen_evt = '0;
  logic adc_result_rd = 1'b0, rx_buf_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic reg_wr = 1'b0;
  logic [NUM_CH-1:0] reg_wdata = '0;
  logic [NUM_CH-1:0] reg_rdata;
  logic irq_valid, irq_to_dma, irq_ack = 1'b0;
  logic [2:0] irq_chan;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_ctrl_front #(.NUM_CH(NUM_CH)) uut (.*);

  // {enable, routing, gen events, exp valid, exp chan, exp dma}
  localparam int NV = 6;
  localparam logic [25:0] VEC [NV] = '{
    {8'hFF, 8'h00, 5'b00001, 1'b1, 3'd3, 1'b0},
    {8'hFF, 8'h20, 5'b10100, 1'b1, 3'd5, 1'b1},
    {8'hDF, 8'h20, 5'b10100, 1'b1, 3'd7, 1'b0},
    {8'h00, 8'hFF, 5'b11111, 1'b0, 3'd0, 1'b0},
    {8'hF0, 8'h10, 5'b00011, 1'b1, 3'd4, 1'b1},
    {8'h80, 8'h80, 5'b11111, 1'b1, 3'd7, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ack;
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1-all actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check("R1 reset register", d, 8'h00);
    end
    check("R1 reset valid", irq_valid, 0);

    // R10 R11 table of priority patterns
    for (int v = 0; v < NV; v++) begin
      wr(2'd0, VEC[v][25:18]);
      wr(2'd1, VEC[v][17:10]);
      gen_evt = VEC[v][9:5];
      @(negedge clk);
      gen_evt = '0;
      check("R10 table valid", irq_valid, VEC[v][4]);
      if (VEC[v][4]) begin
        check("R10 table chan", irq_chan, VEC[v][3:1]);
        check("R11 table dma", irq_to_dma, VEC[v][0]);
      end
      wr(2'd3, 8'hF8);
      rd(2'd3, d);
      check("R12 write clear", d, 8'h00);
    end

    // R2 register access
    wr(2'd0, 8'hA5); rd(2'd0, d); check("R2 enable rw", d, 8'hA5);
    wr(2'd1, 8'h3C); rd(2'd1, d); check("R2 routing rw", d, 8'h3C);
    wr(2'd2, 8'h03); rd(2'd2, d); check("R2 config rw", d, 8'h03);
    wr(2'd2, 8'h00); wr(2'd1, 8'h00);

    // R3 edge mode on pin
    wr(2'd0, 8'h01);
    ext_pin = 1'b1;
    cyc(2);
    check("R3 edge not yet", irq_valid, 0);
    cyc(1);
    check("R3 edge seen", irq_valid, 1);
    check("R3 edge chan", irq_chan, 0);
    cyc(3);
    ext_pin = 1'b0;
    cyc(4);
    check("R3 flag holds after pin falls", irq_valid, 1);
    ack;
    check("R12 ack clears pin flag", irq_valid, 0);

    // R4 level mode
    wr(2'd2, 8'h01);
    ext_pin = 1'b1;
    cyc(1);
    check("R4 level latency", irq_valid, 0);
    cyc(1);
    check("R4 level follows pin", irq_valid, 1);
    ack;
    check("R4 ack no effect in level", irq_valid, 1);
    ext_pin = 1'b0;
    cyc(2);
    check("R4 level drops with pin", irq_valid, 0);

    // R5 mode change clears edge flag
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h00);
    ext_pin = 1'b1; cyc(4); ext_pin = 1'b0; cyc(4);
    rd(2'd3, d); check("R5 edge flag set", d[0], 1);
    wr(2'd2, 8'h01);
    wr(2'd2, 8'h00);
    rd(2'd3, d); check("R5 flag cleared by mode change", d[0], 0);

    // R6 shared source select, timer side
    adc_evt = 1'b1; @(negedge clk); adc_evt = 1'b0;
    rd(2'd3, d); check("R6 adc ignored when timer selected", d[1], 0);
    timer_evt = 1'b1; @(negedge clk); timer_evt = 1'b0;
    rd(2'd3, d); check("R6 timer sets", d[1], 1);
    wr(2'd3, 8'h02);
    rd(2'd3, d); check("R12 timer flag write clear", d[1], 0);

    // R6 ADC side
    wr(2'd2, 8'h02);
    timer_evt = 1'b1; @(negedge clk); timer_evt = 1'b0;
    rd(2'd3, d); check("R6 timer ignored when adc selected", d[1], 0);
    adc_evt = 1'b1; @(negedge clk); adc_evt = 1'b0;
    rd(2'd3, d); check("R6 adc sets", d[1], 1);

    // R8 ADC flag only cleared by result read
    wr(2'd3, 8'h02);
    rd(2'd3, d); check("R8 write ignored", d[1], 1);
    wr(2'd0, 8'h02);
    ack;
    check("R8 ack ignored", irq_valid, 1);
    adc_result_rd = 1'b1; @(negedge clk); adc_result_rd = 1'b0;
    rd(2'd3, d); check("R8 result read clears", d[1], 0);

    // R7 source change clears
    adc_evt = 1'b1; @(negedge clk); adc_evt = 1'b0;
    wr(2'd2, 8'h00);
    rd(2'd3, d); check("R7 source change clears", d[1], 0);

    // R9 receive flag
    rx_evt = 1'b1; @(negedge clk); rx_evt = 1'b0;
    rd(2'd3, d); check("R9 rx sets", d[2], 1);
    wr(2'd3, 8'h04);
    rd(2'd3, d); check("R9 write ignored", d[2], 1);
    wr(2'd0, 8'h04);
    ack;
    check("R9 ack ignored", irq_valid, 1);
    check("R10 rx chan", irq_chan, 2);
    rx_buf_rd = 1'b1; @(negedge clk); rx_buf_rd = 1'b0;
    rd(2'd3, d); check("R9 buffer read clears", d[2], 0);

    // R12 event wins over same-cycle clear on a general channel
    wr(2'd0, 8'h00);
    reg_addr = 2'd3; reg_wdata = 8'h08; reg_wr = 1'b1; gen_evt = 5'b00001;
    @(negedge clk);
    reg_wr = 1'b0; gen_evt = '0;
    rd(2'd3, d); check("R12 set beats clear", d[3], 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule